// File: doc/BRIEF.md
# Framed 14-bit PCM Serial Port

This block is a synchronous serial port. In each frame it carries one 14-bit two's-complement sample towards the converter and one away from it. It runs entirely on an external bit clock. A frame strobe, whose rising edge marks the sign bit, aligns the frames. Receive bits are taken on the falling clock edge, shifted into a word, and handed over as a parallel sample with a one-period valid pulse. Transmit samples are captured in parallel when the frame strobe rises and then sent sign bit first, one bit per rising clock edge.

The transmit line is open drain. It is modelled as an output-enable plus a pull-low signal, so the surrounding logic or a bench can resolve a pulled-up wire. The line is released outside the 14 data bit times. An enable input stands for the converter power state. While it is low the transmit line stays released and any partial receive frame is dropped. The bit clock may run at 14 to 128 times the frame rate. Clock periods past the 14th bit of a frame carry nothing.

Top module: `pcm14_frame_port`

## Requirements
- R1: While reset is asserted and directly after it, `pcm_oe`, `pcm_drv_low` and `rx_valid` are 0 and `rx_sample` is 0.
- R2: The rising edge of `frame_sync` at a falling clock edge marks the sign bit. That bit and the next 13 bits of `pcm_in` are taken on successive falling edges, most significant first. After the 14th bit, `rx_sample` shows the assembled word and `rx_valid` is 1.
- R3: `rx_valid` is high for exactly one clock period per completed frame.
- R4: Bits on `pcm_in` after the 14th bit of a frame cause no further `rx_valid`, and `rx_sample` holds its value until the next frame completes. `rx_sample` changes only together with `rx_valid`.
- R5: `tx_sample` is captured at the rising clock edge that first sees `frame_sync` high. From that edge on, one bit per rising edge is driven, most significant (bit 13) first. Changes of `tx_sample` at other times have no effect.
- R6: `pcm_oe` is high for exactly 14 clock periods after the capturing edge and then low until the next frame strobe. With 14-clock frames it stays high continuously.
- R7: `pcm_drv_low` is 1 only when `pcm_oe` is 1 and the current transmit bit is 0. The resolved pulled-up line therefore reads 1 for bit value 1 and 0 for bit value 0.
- R8: A new rising edge of `frame_sync` before 14 bits are complete restarts both directions. The partial receive word is discarded without `rx_valid`, and transmission restarts with a newly captured `tx_sample`.
- R9: `pcm_oe` is 0 from the first rising edge at which `en` is low, and no frame starts while `en` is low. A falling edge with `en` low discards any partial receive frame, with no `rx_valid`.
- R10: Full-scale words pass unchanged in both directions: 0x1FFF (most positive), 0x2000 (most negative) and 0x3FFF (minus one).
- R11: The port works for frame lengths from 14 to 128 clock periods and for frame strobe high times of one or more periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; receive samples on falling edge, transmit launches on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter power state; 0 idles both directions |
| frame_sync | input | 1 | Frame strobe; rising edge marks the sign bit |
| pcm_in | input | 1 | Serial receive data |
| tx_sample | input | 14 | Parallel sample to transmit, captured at frame start |
| rx_sample | output | 14 | Last completely received sample |
| rx_valid | output | 1 | One-period pulse when `rx_sample` is updated |
| pcm_oe | output | 1 | High during the 14 transmit bit times |
| pcm_drv_low | output | 1 | Pull the open-drain line low |

## Verification
The hardest situations to reach are a frame cut short: a second frame strobe after a few bits, or the enable dropping partway through. In both, neither direction may leak the partial frame. The bench drives a six-bit partial frame and then a full frame with different words. It also drops the enable at bit five and raises the strobe while disabled. At every bit time it checks that no valid pulse appears, that the line is released, and that the next normal frame carries the new words. A table of frames with lengths from 14 to 128 clocks and strobe widths from one to 64 clocks covers back-to-back 14-clock frames and long stretches of ignored bits.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Default sample width of the serial port.
    localparam int unsigned PCM_WORD_W = 14;

    // Width of a counter that must reach the word width itself.
    function automatic int unsigned pcm_cnt_w(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_d;
    logic level_q;

    always_comb begin
        level_d = level;
    end

    // The sampling edge is chosen by parameter.
    generate
        if (FALLING) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) level_q <= 1'b0;
                else        level_q <= level_d;
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) level_q <= 1'b0;
                else        level_q <= level_d;
            end
        end
    endgenerate

    assign rise = level & ~level_q;

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int unsigned W = pcm_port_pkg::PCM_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         valid
);

    localparam int unsigned CW = pcm_port_pkg::pcm_cnt_w(W);
    localparam logic [CW-1:0] LAST = CW'(W);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          valid;
    } rx_state_t;

    rx_state_t rx_d;
    rx_state_t rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (!en) begin
            rx_d.busy = 1'b0;
            rx_d.cnt  = '0;
        end else if (start || rx_q.busy) begin
            rx_d.sh  = {rx_q.sh[W-2:0], din};
            rx_d.cnt = start ? ONE : rx_q.cnt + 1'b1;
            if (rx_d.cnt == LAST) begin
                rx_d.word  = rx_d.sh;
                rx_d.valid = 1'b1;
                rx_d.busy  = 1'b0;
                rx_d.cnt   = '0;
            end else begin
                rx_d.busy = 1'b1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word  = rx_q.word;
    assign valid = rx_q.valid;

    // R3
    rx_valid_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rx_q.valid |=> !rx_q.valid);

    // R4
    rx_word_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (rx_q.word != $past(rx_q.word)) |-> rx_q.valid);

    // R9
    rx_valid_enabled_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rx_q.valid |-> $past(en));

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
    parameter int unsigned W = pcm_port_pkg::PCM_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         bit_out,
    output logic         oe
);

    localparam int unsigned CW = pcm_port_pkg::pcm_cnt_w(W);
    localparam logic [CW-1:0] LAST = CW'(W);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          oe;
    } tx_state_t;

    tx_state_t tx_d;
    tx_state_t tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!en) begin
            tx_d.oe  = 1'b0;
            tx_d.cnt = '0;
        end else if (start) begin
            tx_d.sh  = load;
            tx_d.cnt = ONE;
            tx_d.oe  = 1'b1;
        end else if (tx_q.oe) begin
            if (tx_q.cnt == LAST) begin
                tx_d.oe  = 1'b0;
                tx_d.cnt = '0;
            end else begin
                tx_d.sh  = {tx_q.sh[W-2:0], 1'b0};
                tx_d.cnt = tx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign bit_out = tx_q.sh[W-1];
    assign oe      = tx_q.oe;

    // R9
    tx_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tx_q.oe);

    // R5
    tx_starts_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q.oe) |-> $past(start));

endmodule

// File: rtl/pcm14_frame_port.sv
module pcm14_frame_port #(
    parameter int unsigned WORD_W = pcm_port_pkg::PCM_WORD_W
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frame_sync,
    input  logic              pcm_in,
    input  logic [WORD_W-1:0] tx_sample,
    output logic [WORD_W-1:0] rx_sample,
    output logic              rx_valid,
    output logic              pcm_oe,
    output logic              pcm_drv_low
);

    logic rx_start;
    logic tx_start;
    logic tx_bit;

    pcm_edge_detect #(.FALLING(1'b1)) i_rx_edge (
        .clk   (bclk),
        .rst_n (rst_n),
        .level (frame_sync),
        .rise  (rx_start)
    );

    pcm_edge_detect #(.FALLING(1'b0)) i_tx_edge (
        .clk   (bclk),
        .rst_n (rst_n),
        .level (frame_sync),
        .rise  (tx_start)
    );

    pcm_rx_deser #(.W(WORD_W)) i_rx (
        .clk   (bclk),
        .rst_n (rst_n),
        .en    (en),
        .start (rx_start),
        .din   (pcm_in),
        .word  (rx_sample),
        .valid (rx_valid)
    );

    pcm_tx_ser #(.W(WORD_W)) i_tx (
        .clk     (bclk),
        .rst_n   (rst_n),
        .en      (en),
        .start   (tx_start),
        .load    (tx_sample),
        .bit_out (tx_bit),
        .oe      (pcm_oe)
    );

    // Open drain: only a zero bit inside the window pulls the line down.
    assign pcm_drv_low = pcm_oe & ~tx_bit;

endmodule

// File: tb/test_pcm14_frame_port.sv
`timescale 1ns/1ps
module test_pcm14_frame_port;

    localparam real CLK_PERIOD = 5.0;
    localparam int  W = 14;

    typedef struct packed {
        logic [13:0] rxw;
        logic [13:0] txw;
        logic [7:0]  len;
        logic [7:0]  sw;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{14'h1FFF, 14'h2000, 8'd16,  8'd1},
        '{14'h2000, 14'h1FFF, 8'd20,  8'd3},
        '{14'h3FFF, 14'h0001, 8'd14,  8'd1},
        '{14'h0000, 14'h3FFF, 8'd14,  8'd7},
        '{14'h0ACE, 14'h3531, 8'd32,  8'd8},
        '{14'h2AAA, 14'h1555, 8'd128, 8'd64},
        '{14'h1555, 14'h2AAA, 8'd15,  8'd2},
        '{14'h0001, 14'h0000, 8'd24,  8'd1}
    };

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        frame_sync = 1'b0;
    logic        pcm_in = 1'b0;
    logic [13:0] tx_sample = '0;
    logic [13:0] rx_sample;
    logic        rx_valid;
    logic        pcm_oe;
    logic        pcm_drv_low;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [13:0] last_rx = '0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    pcm14_frame_port #(.WORD_W(W)) i_pcm14_frame_port (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .en          (en),
        .frame_sync  (frame_sync),
        .pcm_in      (pcm_in),
        .tx_sample   (tx_sample),
        .rx_sample   (rx_sample),
        .rx_valid    (rx_valid),
        .pcm_oe      (pcm_oe),
        .pcm_drv_low (pcm_drv_low)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    // Inputs change 1 ns after a rising edge, away from both edges.
    task automatic adv();
        @(posedge bclk);
        #1;
    endtask

    // Checks on the transmit line after rising edge k of the frame.
    task automatic obs_tx(input bit exp_oe, input logic exp_bit, input string req);
        logic line;
        line = pcm_drv_low ? 1'b0 : 1'b1;
        chk(pcm_oe == exp_oe, {req, " pcm_oe"}, 32'(pcm_oe), 32'(exp_oe));
        if (exp_oe) begin
            // R7: pulled-up line resolves to the bit value
            chk(line == exp_bit, {req, " R7 line"}, 32'(line), 32'(exp_bit));
        end else begin
            chk(pcm_drv_low == 1'b0, {req, " R7 drv_low idle"}, 32'(pcm_drv_low), 32'd0);
        end
    endtask

    task automatic run_frame(input logic [13:0] rxw, input logic [13:0] txw,
                             input int len, input int sw);
        for (int j = 0; j < len; j++) begin
            frame_sync = (j < sw);
            pcm_in     = (j < W) ? rxw[W-1-j] : 1'($urandom);
            tx_sample  = (j == 0) ? txw : 14'($urandom);
            adv();
            begin
                int k;
                k = j + 1;
                if (k <= W) obs_tx(1'b1, txw[W-k], "R5/R6");
                else        obs_tx(1'b0, 1'b1, "R6");
                if (k == W) begin
                    chk(rx_valid == 1'b1, "R2 rx_valid", 32'(rx_valid), 32'd1);
                    chk(rx_sample == rxw, "R2/R10 rx_sample", 32'(rx_sample), 32'(rxw));
                    last_rx = rxw;
                end else begin
                    chk(rx_valid == 1'b0, "R3/R4 rx_valid", 32'(rx_valid), 32'd0);
                    if (k > W)
                        chk(rx_sample == last_rx, "R4 rx_sample hold", 32'(rx_sample), 32'(last_rx));
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and after reset
        adv();
        adv();
        chk(pcm_oe == 1'b0 && pcm_drv_low == 1'b0, "R1 line in reset", 32'({pcm_oe, pcm_drv_low}), 32'd0);
        chk(rx_valid == 1'b0 && rx_sample == '0, "R1 rx in reset", 32'({rx_valid, rx_sample}), 32'd0);
        rst_n = 1'b1;
        adv();
        adv();
        chk(pcm_oe == 1'b0 && pcm_drv_low == 1'b0, "R1 line after reset", 32'({pcm_oe, pcm_drv_low}), 32'd0);
        chk(rx_valid == 1'b0 && rx_sample == '0, "R1 rx after reset", 32'({rx_valid, rx_sample}), 32'd0);

        // R10, R11: table of frames of various lengths and strobe widths
        for (int v = 0; v < NV; v++) begin
            run_frame(VECS[v].rxw, VECS[v].txw, int'(VECS[v].len), int'(VECS[v].sw));
        end

        // R8: partial frame of six bits, then a new strobe
        begin
            logic [13:0] ptx;
            ptx = 14'h2C3A;
            for (int j = 0; j < 6; j++) begin
                frame_sync = (j == 0);
                pcm_in     = 1'($urandom);
                tx_sample  = (j == 0) ? ptx : 14'($urandom);
                adv();
                obs_tx(1'b1, ptx[W-1-j], "R8 partial");
                chk(rx_valid == 1'b0, "R8 no valid on partial", 32'(rx_valid), 32'd0);
            end
            chk(rx_sample == last_rx, "R8 rx_sample kept", 32'(rx_sample), 32'(last_rx));
            run_frame(14'h1234, 14'h0F0F, 18, 1);
        end

        // R9: enable drops at bit five; strobe while disabled
        for (int j = 0; j < 20; j++) begin
            frame_sync = (j < 2) || (j == 10) || (j == 11);
            pcm_in     = 1'b1;
            tx_sample  = (j == 0) ? 14'h3E01 : 14'($urandom);
            en         = (j < 5) || (j == 19);
            adv();
            if (j + 1 <= 5) obs_tx(1'b1, 14'h3E01 >> (W - 1 - j), "R9 before drop");
            else            obs_tx(1'b0, 1'b1, "R9 disabled");
            chk(rx_valid == 1'b0, "R9 no valid", 32'(rx_valid), 32'd0);
            chk(rx_sample == last_rx, "R9 rx_sample kept", 32'(rx_sample), 32'(last_rx));
        end
        run_frame(14'h0BEE, 14'h2468, 16, 2);

        // R11: back-to-back shortest frames keep the line enabled
        run_frame(14'h3FFF, 14'h2000, 14, 1);
        run_frame(14'h2000, 14'h3FFF, 14, 13);
        run_frame(14'h1FFF, 14'h1FFF, 16, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule